// File: doc/BRIEF.md
# Noise-Immune TRS Word Framer

The framer takes a 20-bit word stream that has already been descrambled but is not yet aligned to word boundaries. The stream carries two 10-bit channels: luma in bits 19:10 and chroma in bits 9:0. Each channel keeps a 40-bit history of its own bits. In the channel chosen by a select input, the framer looks for the timing reference preamble (3FF, 000, 000) at every one of the ten bit offsets. From the offset it finds, it cuts aligned words out of both channel histories.

Two policies govern when a new offset is taken. In normal mode the framer moves to the offset of every preamble it finds. In noise-immune mode it first holds a new offset as a candidate. It adopts that offset only when the next preamble appears at the same offset. A bypass input sends each channel's newest raw word through with no alignment and freezes the framing state. A flag output marks the cycle whose output words belong to a detected preamble.

Top module: `trs_word_framer`

## Requirements
- R1: Input bits 19:10 form the luma channel and bits 9:0 the chroma channel. The luma_o and chroma_o outputs carry the words of the matching channels. In each channel the bit stream runs from the older word to the newer one, and from MSB to LSB within a word.
- R2: trs_found_o is high in exactly those cycles whose output words are taken from a history that ends in the 30-bit sequence 3FF, 000, 000 at some offset 0..9 in the selected channel. This holds in every mode. The output path has a two-clock latency from data_i.
- R3: sel_luma_i high searches the luma channel for the preamble; low searches the chroma channel. A preamble in the channel that is not selected is ignored.
- R4: With noise_imm_i low, every detected preamble sets the offset to its own. The output words of that same cycle already use the new offset.
- R5: With noise_imm_i high, a preamble at a new offset only becomes a pending candidate. The offset changes when the next detected preamble appears at that same candidate offset.
- R6: With noise_imm_i high, a pending candidate is replaced by any later preamble at a different new offset. A preamble at the current offset clears the candidate.
- R7: With bypass_i high, each output is the channel's newest input word, delayed by two clocks. The offset and the candidate do not change.
- R8: After reset the outputs are zero, the offset is 0 and no candidate is pending.
- R9: Both channels are always cut at the same offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 20 | Unaligned input, luma 19:10, chroma 9:0 |
| sel_luma_i | input | 1 | 1: search luma, 0: search chroma |
| noise_imm_i | input | 1 | 1: adopt a new offset only after a repeat |
| bypass_i | input | 1 | 1: pass raw words, freeze framing |
| luma_o | output | 10 | Aligned luma word |
| chroma_o | output | 10 | Aligned chroma word |
| trs_found_o | output | 1 | Preamble detected in selected channel |

## Verification
The assertions take the three control inputs to be steady for a whole clock around each edge. They also rely on the fact that the preamble pattern cannot match at two offsets of one history at once. The stimulus changes controls only together with the data at the falling edge. Preambles are inserted at chosen offsets into otherwise random bits. A reference model that scans its own copy of the history predicts all outputs, including any accidental preamble that the random bits produce.

// File: rtl/trs_framer_pkg.sv
package trs_framer_pkg;
  localparam int WORD_W = 10;
  localparam int N_CH   = 2;
  localparam int OFF_W  = $clog2(WORD_W);
  localparam int HIST_W = 4 * WORD_W;
  localparam int CH_Y   = 1;
  localparam int CH_C   = 0;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [OFF_W-1:0]  off_t;
  typedef logic [HIST_W-1:0] hist_t;
endpackage

// File: rtl/trs_hist.sv
module trs_hist
  import trs_framer_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  word_t din_i,
  output hist_t hist_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) hist_o <= '0;
    else         hist_o <= {hist_o[HIST_W-WORD_W-1:0], din_i};
endmodule

// File: rtl/trs_detect.sv
module trs_detect
  import trs_framer_pkg::*;
(
  input  hist_t hist_i,
  output logic  hit_o,
  output off_t  off_o
);
  localparam word_t ONES = {WORD_W{1'b1}};

  always_comb begin
    hit_o = 1'b0;
    off_o = '0;
    // descending scan so the lowest offset wins
    for (int k = WORD_W - 1; k >= 0; k--) begin
      if (hist_i[k + 2*WORD_W +: WORD_W] == ONES &&
          hist_i[k + WORD_W +: WORD_W] == '0 &&
          hist_i[k +: WORD_W] == '0) begin
        hit_o = 1'b1;
        off_o = off_t'(k);
      end
    end
  end
endmodule

// File: rtl/trs_align_ctl.sv
module trs_align_ctl
  import trs_framer_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  off_t hit_off_i,
  input  logic noise_imm_i,
  input  logic bypass_i,
  output off_t off_nxt_o
);
  off_t off_q, pend_off_q, pend_off_nxt;
  logic pend_q, pend_nxt;

  always_comb begin
    off_nxt_o    = off_q;
    pend_nxt     = pend_q;
    pend_off_nxt = pend_off_q;
    if (hit_i && !bypass_i) begin
      if (!noise_imm_i) begin
        off_nxt_o = hit_off_i;
        pend_nxt  = 1'b0;
      end else if (hit_off_i == off_q) begin
        pend_nxt  = 1'b0;
      end else if (pend_q && hit_off_i == pend_off_q) begin
        off_nxt_o = hit_off_i;
        pend_nxt  = 1'b0;
      end else begin
        pend_nxt     = 1'b1;
        pend_off_nxt = hit_off_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      off_q      <= '0;
      pend_q     <= 1'b0;
      pend_off_q <= '0;
    end else begin
      off_q      <= off_nxt_o;
      pend_q     <= pend_nxt;
      pend_off_q <= pend_off_nxt;
    end

  AST_OFF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(off_q) < WORD_W); // R4
  AST_NORM_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !noise_imm_i && !bypass_i) |=> off_q == $past(hit_off_i)); // R4
  AST_NI_FIRST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && noise_imm_i && !bypass_i && !pend_q) |=> $stable(off_q)); // R5
  AST_BYPASS_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |=> ($stable(off_q) && $stable(pend_q))); // R7
endmodule

// File: rtl/trs_word_framer.sv
module trs_word_framer
  import trs_framer_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_CH*WORD_W-1:0] data_i,
  input  logic                  sel_luma_i,
  input  logic                  noise_imm_i,
  input  logic                  bypass_i,
  output logic [WORD_W-1:0]     luma_o,
  output logic [WORD_W-1:0]     chroma_o,
  output logic                  trs_found_o
);
  hist_t hist [N_CH];
  logic  hit  [N_CH];
  off_t  hoff [N_CH];
  word_t word_q [N_CH];
  logic  sel_hit;
  off_t  sel_off, off_nxt;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    trs_hist u_hist (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .din_i  (data_i[c*WORD_W +: WORD_W]),
      .hist_o (hist[c])
    );
    trs_detect u_det (
      .hist_i (hist[c]),
      .hit_o  (hit[c]),
      .off_o  (hoff[c])
    );
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)       word_q[c] <= '0;
      else if (bypass_i) word_q[c] <= hist[c][WORD_W-1:0];
      else               word_q[c] <= hist[c][off_nxt +: WORD_W];
  end

  assign sel_hit = sel_luma_i ? hit[CH_Y]  : hit[CH_C];
  assign sel_off = sel_luma_i ? hoff[CH_Y] : hoff[CH_C];

  trs_align_ctl u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (sel_hit),
    .hit_off_i   (sel_off),
    .noise_imm_i (noise_imm_i),
    .bypass_i    (bypass_i),
    .off_nxt_o   (off_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) trs_found_o <= 1'b0;
    else         trs_found_o <= sel_hit;

  assign luma_o   = word_q[CH_Y];
  assign chroma_o = word_q[CH_C];

  AST_FOUND_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trs_found_o && !$past(bypass_i) && !$past(noise_imm_i)) |->
      ((sel_luma_i ? luma_o : chroma_o) == '0 || $past(sel_luma_i) != sel_luma_i)); // R4
  AST_BYPASS_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |=> chroma_o == $past(hist[CH_C][WORD_W-1:0])); // R7
endmodule

// File: tb/sim_trs_word_framer.sv
`timescale 1ns/1ps
module sim_trs_word_framer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [19:0] data_i = '0;
  logic sel_luma = 1'b1, ni = 1'b0, byp = 1'b0;
  logic [9:0] luma, chroma;
  logic found;

  always #2 clk = ~clk;

  trs_word_framer u0 (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data_i), .sel_luma_i(sel_luma),
    .noise_imm_i(ni), .bypass_i(byp), .luma_o(luma), .chroma_o(chroma),
    .trs_found_o(found)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  string phase = "R8";
  logic [39:0] mh [2];
  int m_off = 0, m_poff = 0;
  bit m_pv = 1'b0, e_valid = 1'b0;
  logic [9:0] e_l = '0, e_c = '0;
  bit e_f = 1'b0;

  function automatic int find_pre(logic [39:0] h);
    for (int k = 0; k < 10; k++)
      if (h[k+20 +: 10] == 10'h3ff && h[k+10 +: 10] == 10'h000 && h[k +: 10] == 10'h000)
        return k;
    return -1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(logic [19:0] d, logic s, logic n, logic b);
    int k;
    @(negedge clk);
    if (e_valid) begin
      chk(phase, int'(luma), int'(e_l));
      chk("R9", int'(chroma), int'(e_c));
      chk("R2", int'(found), int'(e_f));
    end
    data_i = d; sel_luma = s; ni = n; byp = b;
    k = find_pre(mh[s ? 1 : 0]);
    e_f = (k >= 0);
    if (k >= 0 && !b) begin
      if (!n) begin m_off = k; m_pv = 0; end
      else if (k == m_off) m_pv = 0;
      else if (m_pv && k == m_poff) begin m_off = k; m_pv = 0; end
      else begin m_pv = 1; m_poff = k; end
    end
    e_l = b ? mh[1][9:0] : mh[1][m_off +: 10];
    e_c = b ? mh[0][9:0] : mh[0][m_off +: 10];
    mh[1] = {mh[1][29:0], d[19:10]};
    mh[0] = {mh[0][29:0], d[9:0]};
    e_valid = 1'b1;
  endtask

  // preamble at bit offset k of channel ch, framed by random bits
  task automatic inject(int ch, int k, logic s, logic n, logic b);
    logic [49:0] g;
    g = {$urandom, $urandom};
    g[k +: 30] = {10'h3ff, 20'h0};
    for (int i = 0; i < 5; i++) begin
      logic [9:0] w, r;
      w = g[49 - 10*i -: 10];
      r = 10'($urandom);
      step(ch == 1 ? {w, r} : {r, w}, s, n, b);
    end
  endtask

  task automatic filler(int cnt, logic s, logic n, logic b);
    for (int i = 0; i < cnt; i++) step(20'($urandom), s, n, b);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mh[0] = '0; mh[1] = '0;
    repeat (2) @(negedge clk);
    // R8: reset state visible before and right after release
    chk("R8", int'(luma), 0);
    chk("R8", int'(chroma), 0);
    chk("R8", int'(found), 0);
    rst_n = 1'b1;
    filler(3, 1, 0, 0);
    phase = "R4";
    inject(1, 7, 1, 0, 0); filler(4, 1, 0, 0);
    inject(1, 2, 1, 0, 0); filler(4, 1, 0, 0);
    inject(1, 9, 1, 0, 0); filler(3, 1, 0, 0);
    phase = "R3";
    inject(0, 4, 0, 0, 0); filler(3, 0, 0, 0);
    inject(1, 6, 0, 0, 0); filler(3, 0, 0, 0);
    inject(0, 0, 1, 0, 0); filler(3, 1, 0, 0);
    phase = "R5";
    inject(1, 3, 1, 0, 0); filler(2, 1, 1, 0);
    inject(1, 8, 1, 1, 0); filler(3, 1, 1, 0);
    inject(1, 8, 1, 1, 0); filler(3, 1, 1, 0);
    phase = "R6";
    inject(1, 1, 1, 1, 0); filler(2, 1, 1, 0);
    inject(1, 5, 1, 1, 0); filler(2, 1, 1, 0);
    inject(1, 1, 1, 1, 0); filler(2, 1, 1, 0);
    inject(1, 8, 1, 1, 0); filler(2, 1, 1, 0);
    inject(1, 1, 1, 1, 0); filler(2, 1, 1, 0);
    inject(1, 1, 1, 1, 0); filler(3, 1, 1, 0);
    phase = "R7";
    inject(1, 4, 1, 0, 1); filler(3, 1, 0, 1);
    inject(0, 2, 0, 1, 1); filler(3, 0, 1, 1);
    filler(4, 1, 0, 0);
    phase = "R1";
    for (int t = 0; t < 1500; t++) begin
      logic s, n, b;
      s = 1'($urandom); n = 1'($urandom); b = ($urandom % 8) == 0;
      if ($urandom % 3 == 0) inject(int'($urandom % 2), int'($urandom % 10), s, n, b);
      filler(int'($urandom % 4), s, n, b);
    end
    step(20'h0, 1, 0, 0);
    @(negedge clk);
    chk(phase, int'(luma), int'(e_l));
    chk("R9", int'(chroma), int'(e_c));
    chk("R2", int'(found), int'(e_f));
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule